// File: doc/BRIEF.md
# Two-Stage Long-Format Access Permission Evaluator

This block decides whether one memory access may proceed, given the permission fields of a translation entry in the 64-bit long-descriptor format. It serves both translation stages. For a first-stage entry it expands a 2-bit access code into separate privileged and unprivileged read, write and execute rights. It then picks the set that matches the effective privilege of the access. Finally it removes execute rights under the write-implies-no-execute control and the secure-fetch control. For a second-stage entry it takes read and write rights directly from the two hypervisor permission bits.

Each request carries the entry fields, the stage select, the privilege and the access kind. One cycle later the block returns a grant flag. In the same cycle it returns the read right of the entry, so that a caller can report a refused atomic access as a read fault when the read right was also missing. A new request may be presented on every cycle.

Top module: `lpd_perm_eval`

## Requirements
- R1: `outValid` is low after reset. Every cycle with `inValid` high yields exactly one cycle of `outValid` one clock later, carrying that request's result, and idle cycles yield no result.
- R2: At stage 2 (`inStage2`=1), a read (kind 0) is granted iff `inHap[0]`=1 and a write (kind 1) is granted iff `inHap[1]`=1.
- R3: At stage 2, a fetch (kind 2) is granted iff `inHap[0]`=1 and `inXn`=0.
- R4: At stage 2, an atomic (kind 3) is granted iff `inHap[0]`=1 or `inHap[1]`=1.
- R5: At stage 1 with `inHasUnpriv`=1, the code `inAp` gives privileged read/write and unprivileged read/write as follows: 0 gives 1/1 and 0/0; 1 gives 1/1 and 1/1; 2 gives 1/0 and 0/0; 3 gives 1/0 and 1/0. Reads and writes use the privileged pair when `inPriv`=1 and the unprivileged pair otherwise.
- R6: At stage 1 with `inHasUnpriv`=1 and `inPriv`=1, execute is permitted only when `inPxn`=0 and the unprivileged write right is 0.
- R7: At stage 1 with `inHasUnpriv`=1 and `inPriv`=0, execute is permitted only when `inXn`=0.
- R8: At stage 1 with `inHasUnpriv`=0, read is always permitted, write is permitted iff `inAp[1]`=0, and execute iff `inXn`=0. `inPriv`, `inAp[0]` and `inPxn` have no effect.
- R9: At stage 1, execute is removed when `inWxn`=1 and the write right is granted.
- R10: At stage 1, execute is removed when `inSif`=1, `inSecure`=1 and `inPageNs`=1.
- R11: At stage 1, an atomic is granted only when both the read and the write rights are granted. A fetch is granted iff execute remains.
- R12: `outGrantRead` equals the entry's read right (after privilege selection at stage 1, `inHap[0]` at stage 2), whatever the access kind. It appears in the same cycle as `outGrant`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| inStage2 | input | 1 | 1 selects second-stage evaluation |
| inPriv | input | 1 | Effective privilege of the access |
| inKind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 atomic |
| inAp | input | 2 | First-stage access code |
| inHap | input | 2 | Second-stage permission bits: bit 0 read, bit 1 write |
| inXn | input | 1 | Execute-never (unprivileged execute-never at stage 1) |
| inPxn | input | 1 | Privileged execute-never |
| inWxn | input | 1 | Write-implies-no-execute control |
| inSif | input | 1 | Secure-fetch-from-non-secure suppression control |
| inSecure | input | 1 | Access is made from the secure state |
| inPageNs | input | 1 | Entry maps a non-secure page |
| inHasUnpriv | input | 1 | Regime has an unprivileged level |
| outValid | output | 1 | Result valid |
| outGrant | output | 1 | Access permitted |
| outGrantRead | output | 1 | Read right of the entry for this access |

## Verification
The bench sweeps every combination of the entry fields, controls and access kinds, with idle gaps in between. This exercises each corner listed here. One corner is a privileged fetch on a page with unprivileged write. A design that ignored the unprivileged write would let the kernel execute pages that user code can write. Another is the atomic rule, which differs between the two stages. Mixing the two rules up grants stage-1 atomics on read-only pages or refuses stage-2 atomics on write-only pages. Regimes without an unprivileged level are checked as well: a design that still used the privilege input or the low code bit there would give different write grants for the two privilege values. A wrong `outGrantRead` on a refused atomic would make the caller report the wrong fault type.

// File: rtl/lpd_perm_pkg.sv
package lpd_perm_pkg;
  localparam int KIND_W = 2;
  localparam int AP_W   = 2;
  localparam int HAP_W  = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_READ   = 2'd0,
    KIND_WRITE  = 2'd1,
    KIND_FETCH  = 2'd2,
    KIND_ATOMIC = 2'd3
  } accKind_e;

  typedef struct packed {
    logic capture;
    logic isRead;
    logic isWrite;
    logic isFetch;
    logic isAtomic;
  } permStrobe_t;
endpackage

// File: rtl/lpd_perm_ctrl.sv
module lpd_perm_ctrl
  import lpd_perm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic [KIND_W-1:0] inKind,
  output permStrobe_t       strobe,
  output logic              outValid
);
  accKind_e kind;
  assign kind = accKind_e'(inKind);

  always_comb begin
    strobe          = '0;
    strobe.capture  = inValid;
    strobe.isRead   = (kind == KIND_READ);
    strobe.isWrite  = (kind == KIND_WRITE);
    strobe.isFetch  = (kind == KIND_FETCH);
    strobe.isAtomic = (kind == KIND_ATOMIC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

  // R1: one result per accepted request, one cycle later
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  assert_one_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({strobe.isRead, strobe.isWrite, strobe.isFetch, strobe.isAtomic}));
endmodule

// File: rtl/lpd_perm_datapath.sv
module lpd_perm_datapath
  import lpd_perm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  permStrobe_t      strobe,
  input  logic             inStage2,
  input  logic             inPriv,
  input  logic [AP_W-1:0]  inAp,
  input  logic [HAP_W-1:0] inHap,
  input  logic             inXn,
  input  logic             inPxn,
  input  logic             inWxn,
  input  logic             inSif,
  input  logic             inSecure,
  input  logic             inPageNs,
  input  logic             inHasUnpriv,
  input  logic             outValid,
  output logic             outGrant,
  output logic             outGrantRead
);
  // stage-1 rights table
  logic privRd, privWr, userRd, userWr;
  always_comb begin
    privRd = 1'b1;
    unique case (inAp)
      2'd0: begin privWr = 1'b1; userRd = 1'b0; userWr = 1'b0; end
      2'd1: begin privWr = 1'b1; userRd = 1'b1; userWr = 1'b1; end
      2'd2: begin privWr = 1'b0; userRd = 1'b0; userWr = 1'b0; end
      default: begin privWr = 1'b0; userRd = 1'b1; userWr = 1'b0; end
    endcase
  end

  logic privEx, userEx;
  assign privEx = !(inPxn || userWr);
  assign userEx = !inXn;

  logic s1Rd, s1Wr, s1ExRaw, s1Ex, sifHit;
  always_comb begin
    if (inHasUnpriv) begin
      s1Rd    = inPriv ? privRd : userRd;
      s1Wr    = inPriv ? privWr : userWr;
      s1ExRaw = inPriv ? privEx : userEx;
    end else begin
      s1Rd    = 1'b1;
      s1Wr    = !inAp[1];
      s1ExRaw = !inXn;
    end
  end
  assign sifHit = inSif && inSecure && inPageNs;
  assign s1Ex   = s1ExRaw && !(inWxn && s1Wr) && !sifHit;

  logic s1Grant, s2Rd, s2Wr, s2Grant;
  always_comb begin
    s1Grant = (strobe.isRead   && s1Rd) ||
              (strobe.isWrite  && s1Wr) ||
              (strobe.isFetch  && s1Ex) ||
              (strobe.isAtomic && s1Rd && s1Wr);
  end
  assign s2Rd = inHap[0];
  assign s2Wr = inHap[1];
  always_comb begin
    s2Grant = (strobe.isRead   && s2Rd) ||
              (strobe.isWrite  && s2Wr) ||
              (strobe.isFetch  && s2Rd && !inXn) ||
              (strobe.isAtomic && (s2Rd || s2Wr));
  end

  logic regStage2, regFetch, regAtomic, regSifHit, regXn;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outGrant     <= 1'b0;
      outGrantRead <= 1'b0;
      regStage2    <= 1'b0;
      regFetch     <= 1'b0;
      regAtomic    <= 1'b0;
      regSifHit    <= 1'b0;
      regXn        <= 1'b0;
    end else if (strobe.capture) begin
      outGrant     <= inStage2 ? s2Grant : s1Grant;
      outGrantRead <= inStage2 ? s2Rd : s1Rd;
      regStage2    <= inStage2;
      regFetch     <= strobe.isFetch;
      regAtomic    <= strobe.isAtomic;
      regSifHit    <= sifHit;
      regXn        <= inXn;
    end
  end

  // R11: a stage-1 atomic grant implies read right
  assert_s1_atomic_needs_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !regStage2 && regAtomic && outGrant) |-> outGrantRead);
  // R4: a stage-2 atomic with read right is always granted
  assert_s2_atomic_either_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && regStage2 && regAtomic && outGrantRead) |-> outGrant);
  // R3: a stage-2 fetch grant needs read right and clear XN
  assert_s2_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && regStage2 && regFetch && outGrant) |-> (outGrantRead && !regXn));
  // R10: secure fetch from a non-secure page never granted at stage 1
  assert_sif_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !regStage2 && regFetch && regSifHit) |-> !outGrant);
endmodule

// File: rtl/lpd_perm_eval.sv
module lpd_perm_eval
  import lpd_perm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       inStage2,
  input  logic       inPriv,
  input  logic [1:0] inKind,
  input  logic [1:0] inAp,
  input  logic [1:0] inHap,
  input  logic       inXn,
  input  logic       inPxn,
  input  logic       inWxn,
  input  logic       inSif,
  input  logic       inSecure,
  input  logic       inPageNs,
  input  logic       inHasUnpriv,
  output logic       outValid,
  output logic       outGrant,
  output logic       outGrantRead
);
  permStrobe_t strobe;

  lpd_perm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inKind(inKind),
    .strobe(strobe), .outValid(outValid)
  );

  lpd_perm_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .inStage2(inStage2), .inPriv(inPriv), .inAp(inAp), .inHap(inHap),
    .inXn(inXn), .inPxn(inPxn), .inWxn(inWxn), .inSif(inSif),
    .inSecure(inSecure), .inPageNs(inPageNs), .inHasUnpriv(inHasUnpriv),
    .outValid(outValid), .outGrant(outGrant), .outGrantRead(outGrantRead)
  );
endmodule

// File: tb/tb_lpd_perm_eval.sv
module tb_lpd_perm_eval;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, inStage2 = 1'b0, inPriv = 1'b0;
  logic [1:0] inKind = '0, inAp = '0, inHap = '0;
  logic inXn = 1'b0, inPxn = 1'b0, inWxn = 1'b0, inSif = 1'b0;
  logic inSecure = 1'b0, inPageNs = 1'b0, inHasUnpriv = 1'b0;
  logic outValid, outGrant, outGrantRead;

  always #2ns clk = ~clk;

  lpd_perm_eval dut (.*);

  typedef struct {
    logic       grant;
    logic       rd;
    string      tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int total = 0, bad = 0, pushed = 0, popped = 0;
  bit done = 1'b0;

  function automatic void checkBit(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endfunction

  // independent reference from the requirements
  function automatic expItem_t model(logic [14:0] v);
    expItem_t e;
    logic st2, pv, xn, pxn, wxn, sif, sec, ns, hu;
    logic [1:0] kd, ap, hap;
    logic pr, pw, ur, uw, r, w, x;
    {st2, pv, kd, ap, hap, xn, pxn, wxn, sif, sec, ns, hu} = v;
    if (st2) begin
      r = hap[0]; w = hap[1];
      case (kd)
        2'd0: begin e.grant = r; e.tag = "R2"; end
        2'd1: begin e.grant = w; e.tag = "R2"; end
        2'd2: begin e.grant = r & ~xn; e.tag = "R3"; end
        default: begin e.grant = r | w; e.tag = "R4"; end
      endcase
      e.rd = r;
      return e;
    end
    pr = 1'b1;
    pw = (ap == 2'd0) || (ap == 2'd1);
    ur = ap[0];
    uw = (ap == 2'd1);
    if (!hu) begin
      r = 1'b1; w = ~ap[1]; x = ~xn; e.tag = "R8";
    end else if (pv) begin
      r = pr; w = pw; x = ~pxn & ~uw; e.tag = (kd == 2'd2) ? "R6" : "R5";
    end else begin
      r = ur; w = uw; x = ~xn; e.tag = (kd == 2'd2) ? "R7" : "R5";
    end
    if (wxn && w) begin
      x = 1'b0;
      if (kd == 2'd2 && hu) e.tag = "R9";
    end
    if (sif && sec && ns) begin
      x = 1'b0;
      if (kd == 2'd2 && hu) e.tag = "R10";
    end
    case (kd)
      2'd0: e.grant = r;
      2'd1: e.grant = w;
      2'd2: e.grant = x;
      default: begin e.grant = r & w; if (hu) e.tag = "R11"; end
    endcase
    e.rd = r;
    return e;
  endfunction

  task automatic drive(logic [14:0] v);
    @(negedge clk);
    {inStage2, inPriv, inKind, inAp, inHap, inXn, inPxn, inWxn, inSif,
     inSecure, inPageNs, inHasUnpriv} = v;
    inValid = 1'b1;
    scoreQ.push_back(model(v));
    pushed++;
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && outValid) begin
        if (scoreQ.size() == 0) begin
          total++; bad++;
          $display("FAIL R1 actual=result expected=no result");
        end else begin
          expItem_t e;
          e = scoreQ.pop_front();
          popped++;
          checkBit(e.tag, outGrant, e.grant);
          checkBit("R12", outGrantRead, e.rd);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkBit("R1 reset", outValid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    checkBit("R1 idle", outValid, 1'b0);
    for (int v = 0; v < 32768; v++) begin
      drive(15'(v));
      if (v % 7 == 6) idle();
    end
    idle();
    @(negedge clk);
    @(negedge clk);
    checkBit("R1 drained", (scoreQ.size() == 0), 1'b1);
    checkBit("R1 count", (pushed == popped), 1'b1);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule